// File: doc/BRIEF.md
# DSSS Symbol-to-Chip Spreader

The spreader turns a packet of 4-bit data symbols into one serial stream of pseudo-noise chips. Each symbol selects one of sixteen 32-chip sequences from a fixed table. The chips of that sequence leave on a single output, one per chip-clock cycle. When a symbol's 32 chips are done, the next symbol's sequence follows at once with no idle cycle. The default packet holds 22 symbols, so a full packet gives 704 chips.

Two clocks drive the block. The slow symbol clock samples the packet bus into a holding register. The chip clock runs the serializer. The chip clock is an exact 8x multiple of the symbol clock and is phase-aligned with it, so for the default rates of 250 kHz and 2 MHz each chip lasts 500 ns. A controller loads the packet, waits for a symbol-clock edge, pulses the reload input and then holds the shift input high for as long as chips should flow. The done flag marks the end of the packet.

Top module: `dsss_spreader`

## Requirements
- R1: An active-low asynchronous reset clears all state: chip_o and done_o read 0 at once, and shifting yields only 0 chips until the first reload.
- R2: Symbol k of the packet sits in sym_pkt_i bits [4k+3:4k]. The bus is sampled on each rising edge of sclk_i, and the packet is spread starting with symbol 0 in ascending order.
- R3: Chip i of a sequence is bit i of its 32-bit table word. Symbol 0 is 32'h744AC39B, so an all-zero symbol starts with chips 1, 1, 0. For symbol s from 1 to 7, the word is the symbol 0 word rotated left by 4*s bits.
- R4: For symbols 8 to 15, the word is the word of symbol s-8 XOR 32'hAAAAAAAA, which inverts every odd-indexed chip.
- R5: On each chip-clock edge with shift_i high and reload_i low, chip_o takes the next chip, starting at the least significant bit of the word.
- R6: After chip 31 of a symbol, the next chip is chip 0 of the following symbol with no gap. A packet gives exactly NUM_SYM*32 chips.
- R7: On a chip-clock edge with shift_i and reload_i both low, chip_o becomes 0 and the stream position is kept. When shifting resumes, the stream continues at the next chip.
- R8: On a chip-clock edge with reload_i high, chip_o and done_o become 0 and the stream restarts at chip 0 of symbol 0. Reload has priority over shift.
- R9: done_o rises in the same cycle that the final chip appears on chip_o. It stays high until the next reload or reset, and any later shift yields 0 chips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Chip clock |
| sclk_i | input | 1 | Symbol clock, chip clock divided by 8, phase-aligned |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_pkt_i | input | NUM_SYM*4 | Packet of symbols, symbol 0 in the low nibble |
| reload_i | input | 1 | Restart the stream at symbol 0 |
| shift_i | input | 1 | Emit the next chip |
| chip_o | output | 1 | Serial chip output |
| done_o | output | 1 | Final chip of the packet has been sent |

## Verification
The properties assume that sclk_i edges coincide with clk_i rising edges. They also assume sym_pkt_i is stable across a symbol-clock edge and reload_i is pulsed only after that edge has captured the packet. Under these assumptions the fast logic never sees the slow register change during a transfer. The bench derives the symbol clock by dividing its own chip clock, changes the packet and the controls only on falling chip-clock edges, and waits more than one symbol-clock period before each reload. The chip-count property relies on shift pulses being counted from the reload that started the packet.

// File: rtl/dsss_spread_pkg.sv
package dsss_spread_pkg;
  localparam int unsigned SYM_W   = 4;
  localparam int unsigned CHIP_N  = 32;
  localparam int unsigned ROT_STEP = 4;
  localparam int unsigned SEQ_N   = 1 << SYM_W;
  localparam logic [CHIP_N-1:0] BASE_SEQ = 32'h744A_C39B;  // bit i = chip i
  localparam logic [CHIP_N-1:0] ODD_MASK = 32'hAAAA_AAAA;

  typedef logic [SYM_W-1:0]  sym_t;
  typedef logic [CHIP_N-1:0] chip_word_t;
endpackage

// File: rtl/dsss_sym_capture.sv
module dsss_sym_capture
  import dsss_spread_pkg::*;
#(
  parameter int unsigned NUM_SYM = 22,
  localparam int unsigned PKT_W = NUM_SYM * SYM_W
) (
  input  logic             sclk_i,
  input  logic             rst_ni,
  input  logic [PKT_W-1:0] pkt_i,
  output logic [PKT_W-1:0] pkt_o
);
  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) pkt_o <= '0;
    else         pkt_o <= pkt_i;
  end
endmodule

// File: rtl/dsss_chip_rom.sv
module dsss_chip_rom
  import dsss_spread_pkg::*;
(
  input  sym_t       sym_i,
  output chip_word_t word_o
);
  chip_word_t tbl [SEQ_N];

  for (genvar g = 0; g < int'(SEQ_N); g++) begin : g_tbl
    localparam int unsigned ROT = ROT_STEP * (g % (SEQ_N / 2));
    chip_word_t rot_w;
    if (ROT == 0) begin : g_base
      assign rot_w = BASE_SEQ;
    end else begin : g_rot
      assign rot_w = (BASE_SEQ << ROT) | (BASE_SEQ >> (CHIP_N - ROT));
    end
    if (g >= int'(SEQ_N / 2)) begin : g_inv
      assign tbl[g] = rot_w ^ ODD_MASK;
    end else begin : g_pos
      assign tbl[g] = rot_w;
    end
  end

  assign word_o = tbl[sym_i];
endmodule

// File: rtl/dsss_chip_serializer.sv
module dsss_chip_serializer
  import dsss_spread_pkg::*;
#(
  parameter int unsigned NUM_SYM = 22,
  localparam int unsigned PKT_W = NUM_SYM * SYM_W,
  localparam int unsigned IDX_W = (NUM_SYM > 1) ? $clog2(NUM_SYM) : 1,
  localparam int unsigned CNT_W = $clog2(CHIP_N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PKT_W-1:0] pkt_i,
  input  logic             reload_i,
  input  logic             shift_i,
  output logic             chip_o,
  output logic             done_o
);
  sym_t             syms [NUM_SYM];
  logic [IDX_W-1:0] idx_q, sel_idx;
  logic [CNT_W-1:0] cnt_q;
  chip_word_t       sreg_q, rom_word;
  logic             active_q, last_chip, last_sym;

  for (genvar g = 0; g < int'(NUM_SYM); g++) begin : g_sym
    assign syms[g] = pkt_i[g*SYM_W +: SYM_W];
  end

  assign last_chip = (cnt_q == CNT_W'(CHIP_N - 1));
  assign last_sym  = (idx_q == IDX_W'(NUM_SYM - 1));
  // ROM looks up symbol 0 on reload, else the symbol after the current one
  assign sel_idx   = reload_i ? '0 : (last_sym ? idx_q : idx_q + IDX_W'(1));

  dsss_chip_rom u_rom (
    .sym_i  (syms[sel_idx]),
    .word_o (rom_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q   <= '0;
      idx_q    <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      done_o   <= 1'b0;
      chip_o   <= 1'b0;
    end else if (reload_i) begin
      sreg_q   <= rom_word;
      idx_q    <= '0;
      cnt_q    <= '0;
      active_q <= 1'b1;
      done_o   <= 1'b0;
      chip_o   <= 1'b0;
    end else if (shift_i && active_q) begin
      chip_o <= sreg_q[0];
      if (last_chip) begin
        cnt_q <= '0;
        if (last_sym) begin
          active_q <= 1'b0;
          done_o   <= 1'b1;
        end else begin
          idx_q  <= sel_idx;
          sreg_q <= rom_word;
        end
      end else begin
        sreg_q <= sreg_q >> 1;
        cnt_q  <= cnt_q + CNT_W'(1);
      end
    end else begin
      chip_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dsss_spreader.sv
module dsss_spreader
  import dsss_spread_pkg::*;
#(
  parameter int unsigned NUM_SYM = 22
) (
  input  logic                     clk_i,
  input  logic                     sclk_i,
  input  logic                     rst_ni,
  input  logic [NUM_SYM*SYM_W-1:0] sym_pkt_i,
  input  logic                     reload_i,
  input  logic                     shift_i,
  output logic                     chip_o,
  output logic                     done_o
);
  logic [NUM_SYM*SYM_W-1:0] pkt_q;

  dsss_sym_capture #(.NUM_SYM(NUM_SYM)) u_cap (
    .sclk_i (sclk_i),
    .rst_ni (rst_ni),
    .pkt_i  (sym_pkt_i),
    .pkt_o  (pkt_q)
  );

  dsss_chip_serializer #(.NUM_SYM(NUM_SYM)) u_ser (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pkt_i    (pkt_q),
    .reload_i (reload_i),
    .shift_i  (shift_i),
    .chip_o   (chip_o),
    .done_o   (done_o)
  );
endmodule

// File: rtl/dsss_spreader_chk.sv
module dsss_spreader_chk #(
  parameter int unsigned NUM_SYM = 22,
  localparam int unsigned TOTAL = NUM_SYM * 32,
  localparam int unsigned CW = $clog2(TOTAL + 1)
) (
  input logic clk_i,
  input logic rst_ni,
  input logic reload_i,
  input logic shift_i,
  input logic chip_o,
  input logic done_o
);
  logic          armed_q;
  logic [CW-1:0] sent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      sent_q  <= '0;
    end else if (reload_i) begin
      armed_q <= 1'b1;
      sent_q  <= '0;
    end else if (armed_q && shift_i && !done_o) begin
      sent_q  <= sent_q + CW'(1);
    end
  end

  AST_UNARMED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> (!chip_o && !done_o)); // R1
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> !chip_o); // R7
  AST_RELOAD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> (!chip_o && !done_o)); // R8
  AST_DONE_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (sent_q == CW'(TOTAL))); // R6
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !reload_i) |=> done_o); // R9
  AST_DONE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !reload_i) |=> !chip_o); // R9
endmodule

bind dsss_spreader dsss_spreader_chk #(.NUM_SYM(NUM_SYM)) u_chk (.*);

// File: tb/dsss_spreader_test.sv
module dsss_spreader_test;
  localparam int NS    = 22;
  localparam int TOTAL = NS * 32;

  // expected sequence words, bit i = chip i (R3, R4)
  localparam logic [31:0] EXP_WORD [16] = '{
    32'h744AC39B, 32'h44AC39B7, 32'h4AC39B74, 32'hAC39B744,
    32'hC39B744A, 32'h39B744AC, 32'h9B744AC3, 32'hB744AC39,
    32'hDEE06931, 32'hEE06931D, 32'hE06931DE, 32'h06931DEE,
    32'h6931DEE0, 32'h931DEE06, 32'h31DEE069, 32'h1DEE0693};

  localparam logic [NS*4-1:0] PKT [4] = '{
    88'h0,
    88'h543210FEDCBA9876543210,
    88'hFEDCBA0123456789ABCDEF,
    88'hA5F0C3E1D2B49687F0A5C3};

  logic clk = 1'b0, sclk = 1'b0, rst_ni = 1'b0;
  logic reload = 1'b0, shift = 1'b0;
  logic [NS*4-1:0] pkt = '0;
  logic chip, done;
  logic [1:0] div = '0;
  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;
  always @(posedge clk) begin
    div <= div + 2'd1;
    if (div == 2'd3) sclk <= ~sclk;
  end

  dsss_spreader #(.NUM_SYM(NS)) uut (
    .clk_i(clk), .sclk_i(sclk), .rst_ni(rst_ni), .sym_pkt_i(pkt),
    .reload_i(reload), .shift_i(shift), .chip_o(chip), .done_o(done));

  function automatic logic exp_chip(logic [NS*4-1:0] p, int n);
    logic [3:0] s;
    s = p[(n / 32) * 4 +: 4];
    return EXP_WORD[s][n % 32];
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_and_reload(logic [NS*4-1:0] p);
    pkt = p;
    repeat (10) step();
    reload = 1'b1; shift = 1'b0;
    step();
    chk("R8 reload chip", chip, 1'b0);
    chk("R8 reload done", done, 1'b0);
    reload = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) step();
    chk("R1 reset chip", chip, 1'b0);
    chk("R1 reset done", done, 1'b0);
    rst_ni = 1'b1;
    shift = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step();
      chk("R1 no reload chip", chip, 1'b0);
    end
    shift = 1'b0;

    // vector walk: full packets (R2 R3 R4 R5 R6 R9)
    for (int p = 0; p < 4; p++) begin
      load_and_reload(PKT[p]);
      shift = 1'b1;
      for (int c = 0; c < TOTAL; c++) begin
        step();
        chk("R2 R3 R4 R5 R6 chip", chip, exp_chip(PKT[p], c));
        if (c == TOTAL - 2) chk("R9 early done", done, 1'b0);
      end
      chk("R9 done at last chip", done, 1'b1);
      step();
      chk("R9 chip after done", chip, 1'b0);
      chk("R9 done held", done, 1'b1);
      shift = 1'b0;
      step();
      chk("R9 done held idle", done, 1'b1);
    end

    // zero symbol leads with 1,1,0 (R3)
    load_and_reload(PKT[0]);
    shift = 1'b1;
    step(); chk("R3 first chip", chip, 1'b1);
    step(); chk("R3 second chip", chip, 1'b1);
    step(); chk("R3 third chip", chip, 1'b0);
    shift = 1'b0;

    // pause across a symbol boundary (R7 R6)
    load_and_reload(PKT[1]);
    shift = 1'b1;
    for (int c = 0; c < 30; c++) step();
    shift = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R7 paused chip", chip, 1'b0);
    end
    shift = 1'b1;
    for (int c = 30; c < 70; c++) begin
      step();
      chk("R7 R6 resumed chip", chip, exp_chip(PKT[1], c));
    end

    // reload with shift high restarts (R8)
    reload = 1'b1;
    step();
    chk("R8 reload over shift", chip, 1'b0);
    reload = 1'b0;
    for (int c = 0; c < 40; c++) begin
      step();
      chk("R8 restart chip", chip, exp_chip(PKT[1], c));
    end

    // reload clears done (R8)
    for (int c = 40; c < TOTAL; c++) step();
    chk("R9 done before reload", done, 1'b1);
    reload = 1'b1;
    step();
    chk("R8 done cleared", done, 1'b0);
    reload = 1'b0;

    // reset mid-stream (R1)
    for (int c = 0; c < 50; c++) step();
    rst_ni = 1'b0;
    #1;
    chk("R1 async chip", chip, 1'b0);
    chk("R1 async done", done, 1'b0);
    step();
    rst_ni = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R1 post reset chip", chip, 1'b0);
    end
    shift = 1'b0;
    step();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule